// File: doc/BRIEF.md
# Secondary Core Power-Up Sequencer

This block takes one secondary processor core, numbered 1 to 3, from fully off to running. A single-cycle start pulse carries the core number and a variant select. The block then walks a fixed chain of register-field writes. It clears the core's coherency status field, asserts the core's reset, removes power gating and releases the isolation clamp. Last, it lets the core out of reset. Each of these writes lands at a bit offset that depends on the core number.

The extended variant adds four steps: an extra mode-field clear, a memory pull-down release, a poll of the core's power-good acknowledge, and a final rewrite of the status word. The basic variant skips these four and runs the other steps in the same order. Microsecond waits come from a prescaler that counts `CYC_PER_US` clock cycles per tick. A retry limit bounds the acknowledge poll, so a core that never confirms power ends the sequence with an error. In that case the clamp and reset stay asserted.

The five control words are modelled as output registers, reset to the fully-off state. `busy_o` is high for the length of a sequence, and `done_o` pulses once when the sequence finishes.

Top module: `core_wake_seq`

## Requirements
- R1: A start request with `core_i` = 0 changes no output word, leaves `busy_o` low, and pulses `done_o` on the next cycle.
- R2: After reset the control words are in their off state:
  - `stat_o` = 0x03030300 (2-bit field 11 at bit 8n for n = 1..3);
  - `pctl0_o` = 0x00FC000E (2-bit mode 11 at bit 18+2(n-1), clamp bit n set);
  - `pctl1_o` = 0x000003F0 (2-bit mode 11 at bit 4+2(n-1));
  - `mempd_o` = 0xFFF00000 (nibble F at bits 28, 24, 20 for cores 1, 2, 3);
  - `clkctl_o` = 0 (reset bit for core n at bit 25+(n-1), 1 = held in reset).
- R3: The first step clears core n's status field at bit 8n to 00. The core's reset bit is set exactly 5·CYC_PER_US+1 cycles after that write.
- R4: In the extended variant (`ext_i` = 1), the mode field at bit 18+2(n-1) of `pctl0_o` is cleared in the same cycle as the status field.
- R5: In the extended variant, the pull-down nibble is cleared one cycle after reset is asserted, and the power mode field is cleared one cycle after that.
- R6: The `pctl1_o` mode field at bit 4+2(n-1) is cleared. In the basic variant this happens one cycle after reset is asserted. The next step then follows a 10 µs wait.
- R7: In the extended variant, `pg_i[n-1]` is sampled once the 10 µs wait ends. Each failed sample adds a further 10 µs wait plus one cycle before the next sample. The clamp is cleared one cycle after a sample reads 1. With `pg_i` held high, the clamp clears 10·CYC_PER_US+2 cycles after the power write; one failed sample makes this 20·CYC_PER_US+3.
- R8: Clamp bit n of `pctl0_o` is cleared while the core is still in reset. The reset bit is cleared exactly one cycle later.
- R9: In the extended variant, the status word saved at the first step is written back one cycle after reset release. `done_o` pulses in that same cycle.
- R10: In the basic variant, the first clamp sample comes 10·CYC_PER_US+1 cycles after the power write. `done_o` pulses in the reset-release cycle, and the `pctl0_o` mode field and `mempd_o` are left untouched.
- R11: `busy_o` stays high from the cycle after the start pulse until `done_o`, with one `done_o` per sequence. Start requests while busy are ignored.
- R12: If POLL_MAX consecutive samples fail, `err_o` is set and `done_o` pulses, with the clamp and reset of that core still asserted. `err_o` clears on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| core_i | input | 2 | Core number to bring up |
| ext_i | input | 1 | 1 selects the extended variant |
| pg_i | input | 3 | Power-good acknowledge, bit n-1 for core n |
| stat_o | output | 32 | Coherency power-status word |
| pctl0_o | output | 32 | Power-control word 0 (mode fields, clamps) |
| pctl1_o | output | 32 | Power-control word 1 (power mode fields) |
| mempd_o | output | 32 | Memory pull-down word |
| clkctl_o | output | 32 | Clock-control word (core reset bits) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Acknowledge poll timed out |

## Verification
The hardest condition to reach from the ports is an acknowledge that arrives only after a failed sample. That case exercises the retry path rather than the direct path. The stimulus watches for the power-mode write, then raises `pg_i` partway through the first retry wait, so exactly one sample fails. The retry limit is made small so that the timeout also completes quickly. A second start is injected mid-sequence, and the other core's fields are then confirmed untouched.

// File: rtl/core_wake_seq.sv
module core_wake_seq #(
  parameter int CYC_PER_US = 100,
  parameter int SETTLE_US  = 5,
  parameter int PWR_US     = 10,
  parameter int POLL_US    = 10,
  parameter int POLL_MAX   = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  core_i,
  input  logic        ext_i,
  input  logic [2:0]  pg_i,
  output logic [31:0] stat_o,
  output logic [31:0] pctl0_o,
  output logic [31:0] pctl1_o,
  output logic [31:0] mempd_o,
  output logic [31:0] clkctl_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o
);
  localparam int MAXUS = (SETTLE_US > PWR_US) ? ((SETTLE_US > POLL_US) ? SETTLE_US : POLL_US)
                                              : ((PWR_US > POLL_US) ? PWR_US : POLL_US);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int UW = $clog2(MAXUS + 1);
  localparam int NW = $clog2(POLL_MAX + 1);
  localparam logic [31:0] STAT_OFF  = 32'h0303_0300;
  localparam logic [31:0] PCTL0_OFF = 32'h00FC_000E;
  localparam logic [31:0] PCTL1_OFF = 32'h0000_03F0;
  localparam logic [31:0] MEMPD_OFF = 32'hFFF0_0000;

  typedef enum logic [3:0] {
    S_IDLE, S_STAT, S_WSET, S_RST, S_PD, S_PWR, S_WPWR,
    S_POLL, S_WPOLL, S_ISO, S_REL, S_RESTAT
  } st_t;

  st_t st;
  logic [1:0]    core_q;
  logic          ext_q;
  logic [31:0]   stat_q, pctl0_q, pctl1_q, mempd_q, clk_q, snap_q;
  logic          busy_q, done_q, err_q;
  logic [PW-1:0] pre;
  logic [UW-1:0] us;
  logic [NW-1:0] tries;

  logic [1:0] idx;
  logic [4:0] o_st, o_m0, o_rst, o_pd, o_m1;
  assign idx   = core_q - 2'd1;
  assign o_st  = {core_q, 3'b000};
  assign o_m0  = 5'd18 + {2'b00, idx, 1'b0};
  assign o_rst = 5'd25 + {3'b000, idx};
  assign o_pd  = 5'd28 - {1'b0, idx, 2'b00};
  assign o_m1  = 5'd4 + {2'b00, idx, 1'b0};

  logic waiting, tick, wend;
  assign waiting = (st == S_WSET) || (st == S_WPWR) || (st == S_WPOLL);
  assign tick    = pre == PW'(CYC_PER_US - 1);
  assign wend    = tick && (us == UW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      core_q  <= 2'd1;
      ext_q   <= 1'b0;
      stat_q  <= STAT_OFF;
      pctl0_q <= PCTL0_OFF;
      pctl1_q <= PCTL1_OFF;
      mempd_q <= MEMPD_OFF;
      clk_q   <= '0;
      snap_q  <= STAT_OFF;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      pre     <= '0;
      us      <= '0;
      tries   <= '0;
    end else begin
      done_q <= 1'b0;
      if (waiting) begin
        if (tick) begin
          pre <= '0;
          us  <= us - UW'(1);
        end else begin
          pre <= pre + PW'(1);
        end
      end
      case (st)
        S_IDLE: if (start_i) begin
          if (core_i == 2'd0) done_q <= 1'b1;
          else begin
            core_q <= core_i;
            ext_q  <= ext_i;
            busy_q <= 1'b1;
            err_q  <= 1'b0;
            st     <= S_STAT;
          end
        end
        S_STAT: begin
          stat_q[o_st +: 2] <= 2'b00;
          snap_q <= stat_q & ~(32'd3 << o_st);
          if (ext_q) pctl0_q[o_m0 +: 2] <= 2'b00;
          pre <= '0;
          us  <= UW'(SETTLE_US);
          st  <= S_WSET;
        end
        S_WSET: if (wend) st <= S_RST;
        S_RST: begin
          clk_q[o_rst] <= 1'b1;
          st <= ext_q ? S_PD : S_PWR;
        end
        S_PD: begin
          mempd_q[o_pd +: 4] <= 4'h0;
          st <= S_PWR;
        end
        S_PWR: begin
          pctl1_q[o_m1 +: 2] <= 2'b00;
          pre   <= '0;
          us    <= UW'(PWR_US);
          tries <= '0;
          st    <= S_WPWR;
        end
        S_WPWR: if (wend) st <= ext_q ? S_POLL : S_ISO;
        S_POLL: begin
          if (pg_i[idx]) st <= S_ISO;
          else if (tries == NW'(POLL_MAX - 1)) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st     <= S_IDLE;
          end else begin
            tries <= tries + NW'(1);
            pre   <= '0;
            us    <= UW'(POLL_US);
            st    <= S_WPOLL;
          end
        end
        S_WPOLL: if (wend) st <= S_POLL;
        S_ISO: begin
          pctl0_q[core_q] <= 1'b0;
          st <= S_REL;
        end
        S_REL: begin
          clk_q[o_rst] <= 1'b0;
          if (ext_q) st <= S_RESTAT;
          else begin
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st     <= S_IDLE;
          end
        end
        S_RESTAT: begin
          stat_q <= snap_q;
          done_q <= 1'b1;
          busy_q <= 1'b0;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stat_o   = stat_q;
  assign pctl0_o  = pctl0_q;
  assign pctl1_o  = pctl1_q;
  assign mempd_o  = mempd_q;
  assign clkctl_o = clk_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/core_wake_seq_chk.sv
module core_wake_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic [1:0]  core_i,
  input logic        ext_i,
  input logic [2:0]  pg_i,
  input logic [31:0] stat_o,
  input logic [31:0] pctl0_o,
  input logic [31:0] pctl1_o,
  input logic [31:0] mempd_o,
  input logic [31:0] clkctl_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  logic [2:0] iso, rst;
  assign iso = pctl0_o[3:1];
  assign rst = clkctl_o[27:25];

  p_clamp_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(iso) & ~iso) != 3'b0) |-> (($past(iso) & ~iso & ~rst) == 3'b0));

  p_release_after_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(rst) & ~rst) != 3'b0) |-> (($past(rst) & ~rst & iso) == 3'b0));

  p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (busy_o || done_o));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> ($stable(stat_o) && $stable(pctl0_o) && $stable(pctl1_o)
                 && $stable(mempd_o) && $stable(clkctl_o)));

  p_core0_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && core_i == 2'd0 && !busy_o) |=> (done_o && !busy_o));

  p_err_ends_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (done_o && !busy_o));
endmodule

bind core_wake_seq core_wake_seq_chk u_chk (.*);

// File: tb/core_wake_seq_bench.sv
`timescale 1ns/1ps
module core_wake_seq_bench;
  localparam int C = 4;
  localparam int PM = 3;
  localparam logic [31:0] STAT0 = 32'h0303_0300, P00 = 32'h00FC_000E,
                          P10 = 32'h0000_03F0, MPD0 = 32'hFFF0_0000;

  logic clk = 0, rst_n = 0, start = 0, ext_s = 0;
  logic [1:0] core = 0;
  logic [2:0] pg = 0;
  logic [31:0] stat_o, pctl0_o, pctl1_o, mempd_o, clkctl_o;
  logic busy_o, done_o, err_o;
  int total = 0, bad = 0, cyc = 0;
  int t_st, t_m0, t_rst, t_pd, t_pwr, t_iso, t_rel, t_done, gap, ndone;

  always #2 clk = ~clk;

  core_wake_seq #(.CYC_PER_US(C), .POLL_MAX(PM)) u_core_wake_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .core_i(core), .ext_i(ext_s), .pg_i(pg),
    .stat_o(stat_o), .pctl0_o(pctl0_o), .pctl1_o(pctl1_o), .mempd_o(mempd_o),
    .clkctl_o(clkctl_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; start = 0; pg = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_seq(int n, bit ext, int pgm, bit intrude);
    int i = n - 1;
    t_st = -1; t_m0 = -1; t_rst = -1; t_pd = -1; t_pwr = -1;
    t_iso = -1; t_rel = -1; t_done = -1; gap = 0; ndone = 0;
    core = 2'(n); ext_s = ext; pg = (pgm == 0) ? 3'b111 : 3'b000; start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 1; k < 3000; k++) begin
      if (t_st  < 0 && stat_o[8*n +: 2] == 2'b00) t_st = k;
      if (t_m0  < 0 && pctl0_o[18+2*i +: 2] == 2'b00) t_m0 = k;
      if (t_rst < 0 && clkctl_o[25+i]) t_rst = k;
      if (t_pd  < 0 && mempd_o[28-4*i +: 4] == 4'h0) t_pd = k;
      if (t_pwr < 0 && pctl1_o[4+2*i +: 2] == 2'b00) t_pwr = k;
      if (t_iso < 0 && !pctl0_o[n]) t_iso = k;
      if (t_rel < 0 && t_rst >= 0 && !clkctl_o[25+i]) t_rel = k;
      if (done_o) begin ndone++; t_done = k; break; end
      if (!busy_o) gap++;
      if (pgm == 1 && t_pwr >= 0 && k == t_pwr + 10*C + 5) pg = 3'b111;
      if (intrude && k == 20) begin core = (n == 1) ? 2'd2 : 2'd1; ext_s = 1; start = 1; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    repeat (3) begin @(negedge clk); if (done_o) ndone++; end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R2 stat", stat_o, STAT0);
    chk("R2 pctl0", pctl0_o, P00);
    chk("R2 pctl1", pctl1_o, P10);
    chk("R2 mempd", mempd_o, MPD0);
    chk("R2 clkctl", clkctl_o, 0);
    chk("R2 flags", {busy_o, done_o, err_o}, 0);
  endtask

  task automatic t_core0();
    do_reset();
    core = 0; start = 1;
    @(negedge clk);
    start = 0;
    chk("R1 done", done_o, 1);
    chk("R1 busy", busy_o, 0);
    chk("R1 words", stat_o ^ STAT0 | pctl0_o ^ P00 | pctl1_o ^ P10 | mempd_o ^ MPD0 | clkctl_o, 0);
    @(negedge clk);
    chk("R1 pulse", done_o, 0);
  endtask

  task automatic t_basic(int n);
    do_reset();
    run_seq(n, 0, 0, 0);
    chk("R3 settle", t_rst - t_st, 5*C + 1);
    chk("R6 power after reset", t_pwr - t_rst, 1);
    chk("R10 clamp after power", t_iso - t_pwr, 10*C + 1);
    chk("R8 release", t_rel - t_iso, 1);
    chk("R10 done at release", t_done - t_rel, 0);
    chk("R10 untouched", {pctl0_o[31:4] ^ P00[31:4], mempd_o ^ MPD0}, 0);
    chk("R3 stat word", stat_o, STAT0 & ~(32'd3 << (8*n)));
    chk("R6 pctl1 word", pctl1_o, P10 & ~(32'd3 << (4+2*(n-1))));
    chk("R11 busy gap", gap, 0);
    chk("R11 one done", ndone, 1);
  endtask

  task automatic t_ext(int n, int pgm);
    do_reset();
    run_seq(n, 1, pgm, 0);
    chk("R4 mode0 with status", t_m0 - t_st, 0);
    chk("R3 settle", t_rst - t_st, 5*C + 1);
    chk("R5 pulldown", t_pd - t_rst, 1);
    chk("R5 power after pulldown", t_pwr - t_pd, 1);
    chk("R7 clamp after poll", t_iso - t_pwr, (pgm == 0) ? 10*C + 2 : 20*C + 3);
    chk("R8 release", t_rel - t_iso, 1);
    chk("R9 done after rewrite", t_done - t_rel, 1);
    chk("R9 stat word", stat_o, STAT0 & ~(32'd3 << (8*n)));
    chk("R5 mempd word", mempd_o, MPD0 & ~(32'hF << (28-4*(n-1))));
    chk("R11 one done", ndone, 1);
  endtask

  task automatic t_timeout();
    do_reset();
    run_seq(3, 1, 2, 0);
    chk("R12 err", err_o, 1);
    chk("R12 done time", t_done - t_pwr, PM*(10*C + 1));
    chk("R12 clamp kept", pctl0_o[3], 1);
    chk("R12 reset kept", clkctl_o[27], 1);
    run_seq(3, 1, 0, 0);
    chk("R12 err cleared", err_o, 0);
  endtask

  task automatic t_busy_ignore();
    do_reset();
    run_seq(1, 0, 0, 1);
    chk("R11 one done", ndone, 1);
    chk("R11 core2 stat", stat_o[17:16], 2'b11);
    chk("R11 core2 pctl0", {pctl0_o[21:20], pctl0_o[2]}, 3'b111);
    chk("R11 core2 other", {mempd_o[27:24], clkctl_o[26], pctl1_o[7:6]}, 7'h7B);
  endtask

  initial begin
    t_reset_state();
    t_core0();
    t_basic(1);
    t_basic(3);
    t_ext(2, 0);
    t_ext(1, 1);
    t_timeout();
    t_busy_ignore();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule